// File: doc/BRIEF.md
# Packet Head/Tail Splitter

This block sits at the input of a forwarding pipeline. It takes packets as a stream of 32-bit beats. Each packet already carries a one-bit traffic class from an earlier classifier: control or best-effort. Short packets travel whole. A packet no longer than the split threshold (225 bytes by default) goes out complete on the parcel port, which feeds the downstream dispatcher. A longer packet is cut in two. The first 192 bytes (the head) go out as the parcel. Every byte after that (the tail) goes to a packet-buffer write port.

The buffer side reports a handle for the stored tail. The parcel is held back until that handle arrives. A metadata word travels beside the parcel and stays constant for all of its beats. It carries the packet length, the class, a split flag and the tail handle.

The head size is smaller than the threshold, so packets of 193 to 225 bytes exceed the head size and are still never split. The split decision cannot be made before byte 226 arrives. For that reason the block stores up to 57 beats (the threshold rounded up to a whole beat). It then either emits them as the parcel or replays the part beyond the head to the tail port.

The controller has five states:
- GATHER stores incoming beats.
  - It goes to EMIT when end-of-packet arrives at or below the threshold.
  - It goes to REPLAY when the byte count passes the threshold.
- REPLAY sends stored beats 48 onward to the tail port.
  - It goes to AWAIT when the packet had already ended.
  - Otherwise it goes to STREAM.
- STREAM passes the remaining input straight to the tail port. It goes to AWAIT on the tail end-of-packet.
- AWAIT waits for the tail completion pulse, then goes to EMIT.
- EMIT sends the parcel from the store. It returns to GATHER after the last parcel beat.

Top module: `pkt_head_splitter`

## Requirements
- R1: After reset, and after a reset that interrupts a packet, `in_ready` is 1 and both `tail_valid` and `par_valid` are 0; the next packet is then handled normally.
- R2: A packet of L ≤ 225 bytes is emitted whole on the parcel port in ceil(L/4) beats, with data unchanged. `par_sop` is set on the first beat, and `par_eop` with `par_nbytes` = L − 4·(beats−1) on the last. No tail beat is produced.
- R3: A packet of L > 225 bytes produces ceil((L−192)/4) tail beats carrying input beats 48 onward in order. `tail_sop` is on the first tail beat, and `tail_eop` with `tail_nbytes` = L − 192 − 4·(tail beats − 1) on the last.
- R4: A split packet's parcel is exactly 48 beats, holding input beats 0 to 47, with `par_nbytes` = 4 on its last beat.
- R5: A split packet's parcel is not presented before `tail_done` has been sampled high. The `tail_handle` value sampled with it appears in `par_meta[33:18]`, which is zero for an unsplit packet.
- R6: `par_meta[15:0]` is the packet length in bytes. `par_meta[16]` is `in_ctrl` as sampled on the start beat (1 = control). `par_meta[17]` is 1 exactly when the packet was split.
- R7: Lengths 193 to 225 stay unsplit; 225 is the longest unsplit length and 226 the shortest split one.
- R8: When `tail_ready` is low, the tail outputs hold and the input is stalled; no byte is lost or repeated on the tail port.
- R9: When `par_ready` is low, parcel data and metadata hold. `in_ready` is 0 whenever `par_valid` is 1.
- R10: On input, `in_nbytes` is significant only with `in_eop` and gives the valid bytes (1 to 4) of that beat; on both outputs, non-final beats report `*_nbytes` = 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with valid |
| in_data | input | 32 | Input packet data |
| in_sop | input | 1 | First beat of packet |
| in_eop | input | 1 | Last beat of packet |
| in_nbytes | input | 3 | Valid bytes on last beat (1..4) |
| in_ctrl | input | 1 | Traffic class, 1 = control, sampled on first beat |
| tail_valid | output | 1 | Tail beat valid |
| tail_ready | input | 1 | Packet buffer accepts tail beat |
| tail_data | output | 32 | Tail data |
| tail_sop | output | 1 | First tail beat |
| tail_eop | output | 1 | Last tail beat |
| tail_nbytes | output | 3 | Valid bytes of tail beat |
| tail_done | input | 1 | Tail stored, handle valid |
| tail_handle | input | 16 | Buffer handle of stored tail |
| par_valid | output | 1 | Parcel beat valid |
| par_ready | input | 1 | Dispatcher accepts parcel beat |
| par_data | output | 32 | Parcel data |
| par_sop | output | 1 | First parcel beat |
| par_eop | output | 1 | Last parcel beat |
| par_nbytes | output | 3 | Valid bytes of parcel beat |
| par_meta | output | 34 | {handle, split, class, length} |

## Verification
The assertions in the controller rely on three properties of the input side. First, upstream keeps a stalled beat unchanged, and it marks the first beat with start-of-packet and the last with end-of-packet. Second, the byte count on the last beat lies between one and four. Third, the buffer side raises its completion pulse only after the final tail beat has been taken. The bench drives packets as whole beat sequences that change only after acceptance. It derives the last-beat count from the length and pulses completion a programmed number of cycles after it sees the tail's final beat. Under those conditions the hold checks on both outputs and the threshold checks on the emitted metadata are expected to hold.

// File: rtl/phs_pkg.sv
package phs_pkg;

    typedef enum logic [2:0] {
        ST_GATHER = 3'd0,
        ST_REPLAY = 3'd1,
        ST_STREAM = 3'd2,
        ST_AWAIT  = 3'd3,
        ST_EMIT   = 3'd4
    } phs_state_e;

endpackage

// File: rtl/phs_head_store.sv
module phs_head_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 57,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    // R2: writes never land outside the beat store
    assert_store_waddr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (int'(waddr) < DEPTH));

    // R2: reads stay inside the beat store
    assert_store_raddr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(raddr) < DEPTH);

endmodule

// File: rtl/phs_ctrl.sv
module phs_ctrl
    import phs_pkg::*;
#(
    parameter int BEAT_BYTES = 4,
    parameter int NB_W       = 3,
    parameter int IDX_W      = 6,
    parameter int LEN_W      = 16,
    parameter int HANDLE_W   = 16,
    parameter int HEAD_WORDS = 48,
    parameter int BUF_WORDS  = 57,
    parameter int SPLIT_THR  = 225
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                in_sop,
    input  logic                in_eop,
    input  logic [NB_W-1:0]     in_nbytes,
    input  logic                in_ctrl,
    output logic                in_ready,
    input  logic                tail_ready,
    input  logic                tail_done,
    input  logic [HANDLE_W-1:0] tail_handle,
    input  logic                par_ready,
    output logic                tail_valid,
    output logic                tail_sop,
    output logic                tail_eop,
    output logic [NB_W-1:0]     tail_nbytes,
    output logic                tail_from_buf,
    output logic                par_valid,
    output logic                par_sop,
    output logic                par_eop,
    output logic [NB_W-1:0]     par_nbytes,
    output logic                buf_we,
    output logic [IDX_W-1:0]    buf_waddr,
    output logic [IDX_W-1:0]    buf_raddr,
    output logic [LEN_W-1:0]    meta_len,
    output logic                meta_ctrl,
    output logic                meta_split,
    output logic [HANDLE_W-1:0] meta_handle
);

    localparam logic [NB_W-1:0]  FULL_NB   = NB_W'(BEAT_BYTES);
    localparam logic [IDX_W-1:0] HEAD_IDX  = IDX_W'(HEAD_WORDS);
    localparam logic [IDX_W-1:0] HEAD_LAST = IDX_W'(HEAD_WORDS - 1);
    localparam logic [LEN_W-1:0] THR_LEN   = LEN_W'(SPLIT_THR);

    phs_state_e state, state_nxt;

    logic [IDX_W-1:0]    wr_idx, rd_idx, last_idx;
    logic [NB_W-1:0]     last_nb;
    logic [LEN_W-1:0]    byte_cnt;
    logic                cls_q, split_q, ended_q;
    logic [HANDLE_W-1:0] handle_q;

    logic                acc;
    logic [NB_W-1:0]     beat_b;
    logic [LEN_W-1:0]    new_cnt;
    logic                over_thr;
    logic                at_last;

    assign beat_b   = in_eop ? in_nbytes : FULL_NB;
    assign new_cnt  = byte_cnt + LEN_W'(beat_b);
    assign over_thr = new_cnt > THR_LEN;
    assign acc      = in_valid & in_ready;
    assign at_last  = (rd_idx == last_idx);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_GATHER;
        end else begin
            state <= state_nxt;
        end
    end

    // next-state decision
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_GATHER: begin
                if (acc) begin
                    if (over_thr)
                        state_nxt = ST_REPLAY;
                    else if (in_eop)
                        state_nxt = ST_EMIT;
                end
            end
            ST_REPLAY: begin
                if (tail_ready && at_last)
                    state_nxt = ended_q ? ST_AWAIT : ST_STREAM;
            end
            ST_STREAM: begin
                if (acc && in_eop)
                    state_nxt = ST_AWAIT;
            end
            ST_AWAIT: begin
                if (tail_done)
                    state_nxt = ST_EMIT;
            end
            ST_EMIT: begin
                if (par_ready && at_last)
                    state_nxt = ST_GATHER;
            end
            default: state_nxt = ST_GATHER;
        endcase
    end

    // outputs
    always_comb begin
        in_ready      = 1'b0;
        tail_valid    = 1'b0;
        tail_sop      = 1'b0;
        tail_eop      = 1'b0;
        tail_nbytes   = FULL_NB;
        tail_from_buf = 1'b0;
        par_valid     = 1'b0;
        par_sop       = 1'b0;
        par_eop       = 1'b0;
        par_nbytes    = FULL_NB;
        unique case (state)
            ST_GATHER: begin
                in_ready = 1'b1;
            end
            ST_REPLAY: begin
                tail_valid    = 1'b1;
                tail_from_buf = 1'b1;
                tail_sop      = (rd_idx == HEAD_IDX);
                tail_eop      = ended_q && at_last;
                tail_nbytes   = (ended_q && at_last) ? last_nb : FULL_NB;
            end
            ST_STREAM: begin
                in_ready    = tail_ready;
                tail_valid  = in_valid;
                tail_eop    = in_eop;
                tail_nbytes = in_eop ? in_nbytes : FULL_NB;
            end
            ST_AWAIT: begin
                in_ready = 1'b0;
            end
            ST_EMIT: begin
                par_valid  = 1'b1;
                par_sop    = (rd_idx == '0);
                par_eop    = at_last;
                par_nbytes = at_last ? last_nb : FULL_NB;
            end
            default: in_ready = 1'b0;
        endcase
    end

    assign buf_we    = (state == ST_GATHER) && acc;
    assign buf_waddr = wr_idx;
    assign buf_raddr = rd_idx;

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx   <= '0;
            rd_idx   <= '0;
            last_idx <= '0;
            last_nb  <= FULL_NB;
            byte_cnt <= '0;
            cls_q    <= 1'b0;
            split_q  <= 1'b0;
            ended_q  <= 1'b0;
            handle_q <= '0;
        end else begin
            unique case (state)
                ST_GATHER: begin
                    if (acc) begin
                        byte_cnt <= new_cnt;
                        if (in_sop)
                            cls_q <= in_ctrl;
                        if (over_thr) begin
                            split_q  <= 1'b1;
                            ended_q  <= in_eop;
                            last_idx <= wr_idx;
                            last_nb  <= beat_b;
                            rd_idx   <= HEAD_IDX;
                        end else if (in_eop) begin
                            last_idx <= wr_idx;
                            last_nb  <= in_nbytes;
                            rd_idx   <= '0;
                        end else begin
                            wr_idx <= wr_idx + 1'b1;
                        end
                    end
                end
                ST_REPLAY: begin
                    if (tail_ready && !at_last)
                        rd_idx <= rd_idx + 1'b1;
                end
                ST_STREAM: begin
                    if (acc)
                        byte_cnt <= new_cnt;
                end
                ST_AWAIT: begin
                    if (tail_done) begin
                        handle_q <= tail_handle;
                        rd_idx   <= '0;
                        last_idx <= HEAD_LAST;
                        last_nb  <= FULL_NB;
                    end
                end
                ST_EMIT: begin
                    if (par_ready) begin
                        if (at_last) begin
                            wr_idx   <= '0;
                            rd_idx   <= '0;
                            byte_cnt <= '0;
                            split_q  <= 1'b0;
                            ended_q  <= 1'b0;
                            handle_q <= '0;
                        end else begin
                            rd_idx <= rd_idx + 1'b1;
                        end
                    end
                end
                default: wr_idx <= '0;
            endcase
        end
    end

    assign meta_len    = byte_cnt;
    assign meta_ctrl   = cls_q;
    assign meta_split  = split_q;
    assign meta_handle = handle_q;

    // R8: a stalled tail beat keeps its framing
    assert_tail_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tail_valid && !tail_ready) |=> (tail_valid && $stable(tail_sop)
                                         && $stable(tail_eop) && $stable(tail_nbytes)));

    // R9: a stalled parcel beat keeps framing and metadata
    assert_par_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (par_valid && !par_ready) |=> (par_valid && $stable(par_sop) && $stable(par_eop)
                                       && $stable(meta_len) && $stable(meta_handle)
                                       && $stable(meta_split)));

    // R9: no input accepted while a parcel is offered
    assert_no_accept_in_parcel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        par_valid |-> !in_ready);

    // R7: an unsplit parcel never exceeds the threshold
    assert_unsplit_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (par_valid && !meta_split) |-> (meta_len <= THR_LEN));

    // R3: a split parcel always exceeds the threshold
    assert_split_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (par_valid && meta_split) |-> (meta_len > THR_LEN));

    // R5: no handle reported for an unsplit packet
    assert_handle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (par_valid && !meta_split) |-> (meta_handle == '0));

    // R5: a split parcel appears only after the completion pulse
    assert_await_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_AWAIT) && !tail_done) |=> !par_valid);

    // R10: final beats report between one and a full beat of bytes
    assert_eop_nbytes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (par_valid && par_eop) |-> (par_nbytes != '0 && par_nbytes <= FULL_NB));

    // R1: the decision point never runs past the store
    assert_widx_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        int'(wr_idx) < BUF_WORDS);

    // R1: idle right after reset
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!par_valid && !tail_valid));

endmodule

// File: rtl/pkt_head_splitter.sv
module pkt_head_splitter #(
    parameter int BEAT_BYTES = 4,
    parameter int HEAD_BYTES = 192,
    parameter int SPLIT_THR  = 225,
    parameter int LEN_W      = 16,
    parameter int HANDLE_W   = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                in_valid,
    output logic                                in_ready,
    input  logic [8*BEAT_BYTES-1:0]             in_data,
    input  logic                                in_sop,
    input  logic                                in_eop,
    input  logic [$clog2(BEAT_BYTES):0]         in_nbytes,
    input  logic                                in_ctrl,
    output logic                                tail_valid,
    input  logic                                tail_ready,
    output logic [8*BEAT_BYTES-1:0]             tail_data,
    output logic                                tail_sop,
    output logic                                tail_eop,
    output logic [$clog2(BEAT_BYTES):0]         tail_nbytes,
    input  logic                                tail_done,
    input  logic [HANDLE_W-1:0]                 tail_handle,
    output logic                                par_valid,
    input  logic                                par_ready,
    output logic [8*BEAT_BYTES-1:0]             par_data,
    output logic                                par_sop,
    output logic                                par_eop,
    output logic [$clog2(BEAT_BYTES):0]         par_nbytes,
    output logic [LEN_W+2+HANDLE_W-1:0]         par_meta
);

    localparam int DATA_W     = 8 * BEAT_BYTES;
    localparam int NB_W       = $clog2(BEAT_BYTES) + 1;
    localparam int HEAD_WORDS = HEAD_BYTES / BEAT_BYTES;
    localparam int BUF_WORDS  = SPLIT_THR / BEAT_BYTES + 1;
    localparam int IDX_W      = $clog2(BUF_WORDS);

    logic                tail_from_buf;
    logic                buf_we;
    logic [IDX_W-1:0]    buf_waddr, buf_raddr;
    logic [DATA_W-1:0]   buf_rdata;
    logic [LEN_W-1:0]    meta_len;
    logic                meta_ctrl, meta_split;
    logic [HANDLE_W-1:0] meta_handle;

    phs_head_store #(
        .DATA_W (DATA_W),
        .DEPTH  (BUF_WORDS),
        .IDX_W  (IDX_W)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (buf_we),
        .waddr (buf_waddr),
        .wdata (in_data),
        .raddr (buf_raddr),
        .rdata (buf_rdata)
    );

    phs_ctrl #(
        .BEAT_BYTES (BEAT_BYTES),
        .NB_W       (NB_W),
        .IDX_W      (IDX_W),
        .LEN_W      (LEN_W),
        .HANDLE_W   (HANDLE_W),
        .HEAD_WORDS (HEAD_WORDS),
        .BUF_WORDS  (BUF_WORDS),
        .SPLIT_THR  (SPLIT_THR)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_sop        (in_sop),
        .in_eop        (in_eop),
        .in_nbytes     (in_nbytes),
        .in_ctrl       (in_ctrl),
        .in_ready      (in_ready),
        .tail_ready    (tail_ready),
        .tail_done     (tail_done),
        .tail_handle   (tail_handle),
        .par_ready     (par_ready),
        .tail_valid    (tail_valid),
        .tail_sop      (tail_sop),
        .tail_eop      (tail_eop),
        .tail_nbytes   (tail_nbytes),
        .tail_from_buf (tail_from_buf),
        .par_valid     (par_valid),
        .par_sop       (par_sop),
        .par_eop       (par_eop),
        .par_nbytes    (par_nbytes),
        .buf_we        (buf_we),
        .buf_waddr     (buf_waddr),
        .buf_raddr     (buf_raddr),
        .meta_len      (meta_len),
        .meta_ctrl     (meta_ctrl),
        .meta_split    (meta_split),
        .meta_handle   (meta_handle)
    );

    assign tail_data = tail_from_buf ? buf_rdata : in_data;
    assign par_data  = buf_rdata;
    assign par_meta  = {meta_handle, meta_split, meta_ctrl, meta_len};

    // R9: parcel data holds while the dispatcher stalls
    assert_par_data_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (par_valid && !par_ready) |=> $stable(par_data));

    // R8: replayed tail data holds while the buffer stalls
    assert_tail_data_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tail_valid && !tail_ready && tail_from_buf) |=> $stable(tail_data));

endmodule

// File: tb/pkt_head_splitter_tb.sv
module pkt_head_splitter_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 13;
    localparam int THR        = 225;
    localparam int HEADB      = 192;
    localparam int LIMIT      = 4000;

    // vector: [15:0] length, [16] class, [17] tail stall, [18] parcel stall, [23:20] done delay
    localparam logic [23:0] VECS [NVEC] = '{
        24'h010001, 24'h000004, 24'h010005, 24'h040040, 24'h0000C0,
        24'h0100C1, 24'h0400E1, 24'h3000E2, 24'h0200E4, 24'h0100E5,
        24'h76012C, 24'h030400, 24'h2405DC
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_ready, in_sop = 1'b0, in_eop = 1'b0, in_ctrl = 1'b0;
    logic [31:0] in_data = '0;
    logic [2:0]  in_nbytes = 3'd4;
    logic        tail_valid, tail_ready = 1'b1, tail_sop, tail_eop, tail_done = 1'b0;
    logic [31:0] tail_data;
    logic [2:0]  tail_nbytes;
    logic [15:0] tail_handle = '0;
    logic        par_valid, par_ready = 1'b1, par_sop, par_eop;
    logic [31:0] par_data;
    logic [2:0]  par_nbytes;
    logic [33:0] par_meta;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_head_splitter u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sop(in_sop), .in_eop(in_eop), .in_nbytes(in_nbytes), .in_ctrl(in_ctrl),
        .tail_valid(tail_valid), .tail_ready(tail_ready), .tail_data(tail_data),
        .tail_sop(tail_sop), .tail_eop(tail_eop), .tail_nbytes(tail_nbytes),
        .tail_done(tail_done), .tail_handle(tail_handle),
        .par_valid(par_valid), .par_ready(par_ready), .par_data(par_data),
        .par_sop(par_sop), .par_eop(par_eop), .par_nbytes(par_nbytes),
        .par_meta(par_meta)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] word_of(input int p, input int w);
        logic [31:0] r;
        for (int k = 0; k < 4; k++) r[8*k +: 8] = 8'((p * 7 + 4 * w + k) & 255);
        return r;
    endfunction

    task automatic run_pkt(input int p, input int len, input bit cls,
                           input bit tbp, input bit pbp, input int dly);
        int   words, bi, cyc, tcnt, pcnt, since;
        int   exp_pw, exp_tw, exp_pnb, exp_tnb, tnb_seen, pnb_seen;
        bit   split, tend, done_given, done_sent, pdone, early, stab_bad, rdy_bad;
        bit   tbad, pbad, pstall;
        logic [31:0] pd_prev;
        logic [33:0] pm_prev, meta;
        words = (len + 3) / 4;
        split = (len > THR);
        exp_pw  = split ? HEADB / 4 : words;
        exp_pnb = split ? 4 : len - 4 * (exp_pw - 1);
        exp_tw  = split ? (len - HEADB + 3) / 4 : 0;
        exp_tnb = split ? len - HEADB - 4 * (exp_tw - 1) : 0;
        bi = 0; cyc = 0; tcnt = 0; pcnt = 0; since = 0; tnb_seen = 0; pnb_seen = 0;
        tend = 0; done_given = 0; done_sent = 0; pdone = 0; early = 0;
        stab_bad = 0; rdy_bad = 0; tbad = 0; pbad = 0; pstall = 0;
        pd_prev = '0; pm_prev = '0; meta = '0;
        while (!pdone && cyc < LIMIT) begin
            @(negedge clk);
            in_valid  = (bi < words);
            in_data   = word_of(p, bi);
            in_sop    = (bi == 0);
            in_eop    = (bi == words - 1);
            in_nbytes = (bi == words - 1) ? 3'(len - 4 * (words - 1)) : 3'd4;
            in_ctrl   = cls;
            tail_ready = tbp ? (cyc % 3 != 2) : 1'b1;
            par_ready  = pbp ? (cyc % 2 == 1) : 1'b1;
            tail_handle = 16'(16'h1000 + p);
            tail_done = tend && !done_given && (since >= dly);
            if (tail_done) done_given = 1;
            #1;
            if (pstall && (par_valid !== 1'b1 || par_data !== pd_prev || par_meta !== pm_prev))
                stab_bad = 1;
            if (par_valid && in_ready) rdy_bad = 1;
            if (par_valid && split && !done_sent) early = 1;
            if (tail_valid && tail_ready) begin
                if (tail_data !== word_of(p, HEADB / 4 + tcnt)) tbad = 1;
                if (tail_sop !== (tcnt == 0)) tbad = 1;
                if (tail_eop) begin
                    tnb_seen = int'(tail_nbytes);
                    tend = 1;
                end else if (tail_nbytes !== 3'd4) tbad = 1;
                tcnt++;
            end
            if (par_valid && par_ready) begin
                if (par_data !== word_of(p, pcnt)) pbad = 1;
                if (par_sop !== (pcnt == 0)) pbad = 1;
                if (pcnt == 0) meta = par_meta;
                if (par_eop) begin
                    pnb_seen = int'(par_nbytes);
                    pdone = 1;
                end else if (par_nbytes !== 3'd4) pbad = 1;
                pcnt++;
            end
            if (in_valid && in_ready) bi++;
            pstall = par_valid && !par_ready;
            pd_prev = par_data;
            pm_prev = par_meta;
            if (tend && !done_given) since++;
            if (tail_done) done_sent = 1;
            cyc++;
        end
        @(negedge clk);
        in_valid = 0; tail_done = 0; tail_ready = 1; par_ready = 1;
        chk(cyc < LIMIT, "R2", "watchdog", cyc, LIMIT);
        chk(pcnt == exp_pw, split ? "R4" : (len > HEADB ? "R7" : "R2"), "parcel beats", pcnt, exp_pw);
        chk(!pbad, split ? "R4" : "R2", "parcel data/framing", pbad, 0);
        chk(pnb_seen == exp_pnb, "R10", "parcel last nbytes", pnb_seen, exp_pnb);
        chk(tcnt == exp_tw, split ? "R3" : "R7", "tail beats", tcnt, exp_tw);
        if (split) begin
            chk(!tbad, tbp ? "R8" : "R3", "tail data/framing", tbad, 0);
            chk(tnb_seen == exp_tnb, "R3", "tail last nbytes", tnb_seen, exp_tnb);
            chk(!early, "R5", "parcel before completion", early, 0);
        end
        chk(meta[15:0] == 16'(len), "R6", "meta length", meta[15:0], len);
        chk(meta[16] == cls, "R6", "meta class", meta[16], cls);
        chk(meta[17] == split, "R6", "meta split", meta[17], split);
        chk(meta[33:18] == (split ? 16'(16'h1000 + p) : 16'h0), "R5", "meta handle",
            meta[33:18], split ? 16'h1000 + p : 0);
        if (pbp) chk(!stab_bad, "R9", "parcel hold under stall", stab_bad, 0);
        chk(!rdy_bad, "R9", "input ready during parcel", rdy_bad, 0);
    endtask

    task automatic idle_check(input string tag);
        @(negedge clk); #1;
        chk(in_ready === 1'b1, tag, "in_ready idle", in_ready, 1);
        chk(tail_valid === 1'b0, tag, "tail_valid idle", tail_valid, 0);
        chk(par_valid === 1'b0, tag, "par_valid idle", par_valid, 0);
    endtask

    initial begin
        // R1: state during and right after reset
        repeat (3) @(negedge clk);
        idle_check("R1");
        rst_n = 1'b1;
        idle_check("R1");

        for (int v = 0; v < NVEC; v++) begin
            run_pkt(v + 1, int'(VECS[v][15:0]), VECS[v][16], VECS[v][17], VECS[v][18],
                    int'(VECS[v][23:20]));
        end

        // R1: reset in the middle of a long packet
        for (int b = 0; b < 10; b++) begin
            @(negedge clk);
            in_valid = 1; in_data = word_of(40, b); in_sop = (b == 0);
            in_eop = 0; in_nbytes = 3'd4; in_ctrl = 1;
        end
        @(negedge clk);
        in_valid = 0; rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        idle_check("R1");
        run_pkt(41, 100, 1'b0, 1'b0, 1'b0, 0);

        // R7: band edges again, back-to-back after reset recovery
        run_pkt(42, 225, 1'b1, 1'b1, 1'b1, 0);
        run_pkt(43, 226, 1'b0, 1'b1, 1'b1, 1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule